// File: doc/BRIEF.md
# GPIO Bank with Single-Edge Interrupts

This block is a memory-mapped bank of general-purpose pins. The pin count is set by a parameter and may be anything up to 64. Software controls each pin through a small register port: it sets the direction, sets the driven level and reads back the sampled input level. Every pin has an edge detector. A per-pin polarity bit picks whether a rising or a falling transition is captured. Captured edges collect in a status word that software clears by writing ones.

Two outputs leave the bank. The interrupt line is raised when a status bit is set and its interrupt enable is also set. The wake line is raised when a status bit is set and its wake enable is also set. Each register spans two 32-bit words: the low word holds pins 0 to 31 and the word at offset +4 holds the pins above. Bit positions in the high word that have no pin always read as zero.

Pins that should catch both edges are handled by software. After each capture, software flips that pin's polarity bit.

Top module: `gpio_edge_bank`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0. `pin_oe`, `pin_out`, `irq_o` and `wake_o` are all 0, so each pin is an input with rising-edge polarity and its interrupt disabled.
- R2: The output-enable word is at 0x00 and the output-value word is at 0x18. `pin_oe` equals the output-enable bits. `pin_out` carries the output-value bit only where the pin's output-enable bit is 1, and is 0 elsewhere. Both words read back as written.
- R3: The input word at 0x10 returns `pin_in` after a two-flop synchronizer, so a level change is visible within three cycles. Writes to this word have no effect.
- R4: When a pin's polarity bit (word 0x28) is 0, a 0-to-1 transition of the synchronized input sets that pin's status bit. A 1-to-0 transition does not.
- R5: When a pin's polarity bit is 1, a 1-to-0 transition sets the status bit. A 0-to-1 transition does not.
- R6: The status word is at 0x30. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R7: A status bit is set by its edge even when its interrupt enable (word 0x20) is 0. `irq_o` is a register holding the OR over all pins of status AND enable. It follows that OR one cycle later.
- R8: `wake_o` is a register holding the OR over all pins of status AND wake enable (word 0x38). It follows that OR one cycle later, independently of `irq_o`.
- R9: When an edge and a write-one-to-clear reach the same status bit in the same cycle, the bit ends up set.
- R10: Address bit 2 selects the high word, which holds pins 32 and up. High-word bits that have no pin, and the unmapped address 0x08, read 0 and ignore writes. Edges on high pins set status and raise `irq_o` exactly as edges on low pins do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 6 | Byte address: bit 5 selects the interrupt space, bits 4:3 select the register, bit 2 selects the high word |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe; the write takes effect at the clock edge |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pin_in | input | NPINS | Asynchronous pin input levels |
| pin_out | output | NPINS | Driven level, gated by output enable |
| pin_oe | output | NPINS | Per-pin output enable |
| irq_o | output | 1 | Aggregated enabled interrupt |
| wake_o | output | 1 | Aggregated wake request |

## Verification
Two events can land on the same status bit in the same clock: an edge reaching the end of the synchronizer, and a write-one-to-clear from software. The bench provokes this by moving a pin level two cycles before it issues the clearing write to that bit. The two events then reach the status register on the same edge. The bench judges the result by reading the status word back: the bit must still be set, and a later clear with no edge present must empty it.

// File: rtl/gpio_bank_pkg.sv
// Package: shared register map, register identifiers and word helpers for
// the GPIO bank. Assumes no more than 64 pins, held as two 32-bit words.
package gpio_bank_pkg;

    localparam int MAXPINS = 64;
    localparam int WORDW   = 32;

    // Register identifiers, decoded from address bits [5:3].
    typedef enum logic [2:0] {
        RID_OE   = 3'b000,
        RID_NONE = 3'b001,
        RID_IN   = 3'b010,
        RID_OUT  = 3'b011,
        RID_IEN  = 3'b100,
        RID_POL  = 3'b101,
        RID_STAT = 3'b110,
        RID_WAKE = 3'b111
    } reg_id_e;

    // Map an address to a register identifier.
    function automatic reg_id_e decode_reg(input logic [5:0] addr);
        return reg_id_e'(addr[5:3]);
    endfunction

    // Replace one 32-bit half of a 64-bit vector.
    function automatic logic [MAXPINS-1:0] word_merge(
        input logic [MAXPINS-1:0] old_v,
        input logic [WORDW-1:0]   data,
        input logic               hi
    );
        logic [MAXPINS-1:0] r;
        r = old_v;
        if (hi) r[2*WORDW-1:WORDW] = data;
        else    r[WORDW-1:0]       = data;
        return r;
    endfunction

    // Pick one 32-bit half of a 64-bit vector.
    function automatic logic [WORDW-1:0] word_pick(
        input logic [MAXPINS-1:0] v,
        input logic               hi
    );
        return hi ? v[2*WORDW-1:WORDW] : v[WORDW-1:0];
    endfunction

endpackage

// File: rtl/gpio_edge_detect.sv
// Module: per-pin input synchronizer and single-edge detector.
// Passes each pin through two flops, keeps one more delayed sample, and
// flags a transition in the direction its polarity bit selects
// (0 = rising, 1 = falling). Assumes pin_in is asynchronous to clk.
module gpio_edge_detect #(
    parameter int NPINS = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] pol,
    output logic [NPINS-1:0] level,
    output logic [NPINS-1:0] edge_hit
);

    logic [NPINS-1:0] meta_q;
    logic [NPINS-1:0] sync_q;
    logic [NPINS-1:0] prev_q;

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        // Two-flop synchronizer followed by the previous-sample flop.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q[p] <= 1'b0;
                sync_q[p] <= 1'b0;
                prev_q[p] <= 1'b0;
            end else begin
                meta_q[p] <= pin_in[p];
                sync_q[p] <= meta_q[p];
                prev_q[p] <= sync_q[p];
            end
        end

        // Edge in the direction selected by the polarity bit.
        always_comb begin
            if (pol[p]) edge_hit[p] = prev_q[p] & ~sync_q[p];
            else        edge_hit[p] = sync_q[p] & ~prev_q[p];
        end
    end

    assign level = sync_q;

endmodule

// File: rtl/gpio_cfg_regs.sv
// Module: configuration registers of the bank (output enable, output value,
// interrupt enable, polarity, wake enable). Each is NPINS wide and is
// written one 32-bit half at a time. Bits with no pin are not stored.
module gpio_cfg_regs
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  reg_id_e          wr_id,
    input  logic             hi,
    input  logic [WORDW-1:0] wdata,
    output logic [NPINS-1:0] oe,
    output logic [NPINS-1:0] outv,
    output logic [NPINS-1:0] ien,
    output logic [NPINS-1:0] pol,
    output logic [NPINS-1:0] wake
);

    localparam int NCFG = 5;
    localparam reg_id_e CFG_IDS [NCFG] = '{RID_OE, RID_OUT, RID_IEN, RID_POL, RID_WAKE};

    logic [NPINS-1:0] cfg_q [NCFG];

    for (genvar k = 0; k < NCFG; k++) begin : g_cfg
        logic [MAXPINS-1:0] merged;

        // Merge the written half into the zero-padded current value.
        always_comb begin
            merged = word_merge(MAXPINS'(cfg_q[k]), wdata, hi);
        end

        // Storage for one configuration register.
        always_ff @(posedge clk) begin
            if (!rst_n)                         cfg_q[k] <= '0;
            else if (we && wr_id == CFG_IDS[k]) cfg_q[k] <= merged[NPINS-1:0];
        end
    end

    assign oe   = cfg_q[0];
    assign outv = cfg_q[1];
    assign ien  = cfg_q[2];
    assign pol  = cfg_q[3];
    assign wake = cfg_q[4];

endmodule

// File: rtl/gpio_irq_status.sv
// Module: interrupt status word with write-one-to-clear, plus the
// registered interrupt and wake outputs. When an edge and a clear hit the
// same bit in the same cycle, the edge wins.
module gpio_irq_status #(
    parameter int NPINS = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] edge_hit,
    input  logic [NPINS-1:0] clr_mask,
    input  logic [NPINS-1:0] ien,
    input  logic [NPINS-1:0] wake,
    output logic [NPINS-1:0] status,
    output logic             irq_o,
    output logic             wake_o
);

    logic [NPINS-1:0] status_d;

    // Next status: clear what software asked for, then set new edges.
    always_comb begin
        status_d = (status & ~clr_mask) | edge_hit;
    end

    // Status storage.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= status_d;
    end

    // Registered aggregate outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o  <= 1'b0;
            wake_o <= 1'b0;
        end else begin
            irq_o  <= |(status & ien);
            wake_o <= |(status & wake);
        end
    end

endmodule

// File: rtl/gpio_edge_bank.sv
// Module: top of the GPIO bank. Decodes the register port, instantiates
// the synchronizer/edge detector, the configuration registers and the
// status logic, and builds the read mux. Assumes 1 <= NPINS <= 64.
// Reads are combinational; writes take effect at the clock edge.
module gpio_edge_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [5:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    input  logic             reg_we,
    output logic [31:0]      reg_rdata,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic             irq_o,
    output logic             wake_o
);

    reg_id_e          acc_id;
    logic             acc_hi;
    logic [NPINS-1:0] oe_q, out_q, ien_q, pol_q, wake_q;
    logic [NPINS-1:0] level, edge_hit, status_q, clr_mask;
    logic [MAXPINS-1:0] clr_wide;

    // Address decode of the register port.
    always_comb begin
        acc_id = decode_reg(reg_addr);
        acc_hi = reg_addr[2];
    end

    gpio_edge_detect #(.NPINS(NPINS)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .pol      (pol_q),
        .level    (level),
        .edge_hit (edge_hit)
    );

    gpio_cfg_regs #(.NPINS(NPINS)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .wr_id (acc_id),
        .hi    (acc_hi),
        .wdata (reg_wdata),
        .oe    (oe_q),
        .outv  (out_q),
        .ien   (ien_q),
        .pol   (pol_q),
        .wake  (wake_q)
    );

    // Write-one-to-clear mask for the selected half of the status word.
    always_comb begin
        clr_wide = '0;
        if (reg_we && acc_id == RID_STAT)
            clr_wide = word_merge('0, reg_wdata, acc_hi);
        clr_mask = clr_wide[NPINS-1:0];
    end

    gpio_irq_status #(.NPINS(NPINS)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_hit (edge_hit),
        .clr_mask (clr_mask),
        .ien      (ien_q),
        .wake     (wake_q),
        .status   (status_q),
        .irq_o    (irq_o),
        .wake_o   (wake_o)
    );

    // Pin drive: the value leaves only where the output is enabled.
    always_comb begin
        pin_oe  = oe_q;
        pin_out = out_q & oe_q;
    end

    // Read mux; unpopulated bits are zero through the padding.
    always_comb begin
        logic [MAXPINS-1:0] sel_v;
        case (acc_id)
            RID_OE:   sel_v = MAXPINS'(oe_q);
            RID_IN:   sel_v = MAXPINS'(level);
            RID_OUT:  sel_v = MAXPINS'(out_q);
            RID_IEN:  sel_v = MAXPINS'(ien_q);
            RID_POL:  sel_v = MAXPINS'(pol_q);
            RID_STAT: sel_v = MAXPINS'(status_q);
            RID_WAKE: sel_v = MAXPINS'(wake_q);
            default:  sel_v = '0;
        endcase
        reg_rdata = word_pick(sel_v, acc_hi);
    end

endmodule

// File: rtl/gpio_edge_bank_chk.sv
// Module: assertion checker for gpio_edge_bank, attached by bind.
// Observes ports and the signals passed between the submodules.
module gpio_edge_bank_chk #(
    parameter int NPINS = 36
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic [5:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic [NPINS-1:0] pin_out,
    input logic [NPINS-1:0] pin_oe,
    input logic [NPINS-1:0] status,
    input logic [NPINS-1:0] ien,
    input logic [NPINS-1:0] wake,
    input logic [NPINS-1:0] edge_hit,
    input logic             irq_o,
    input logic             wake_o
);

    localparam int LO = (NPINS < 32) ? NPINS : 32;

    AST_PIN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0); // R2

    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status & ~$past(status) & ~$past(edge_hit)) == '0); // R4

    AST_CLEAR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 6'h30) |=>
        (status[LO-1:0] & $past(reg_wdata[LO-1:0]) & ~$past(edge_hit[LO-1:0])) == '0); // R6

    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status & ien)) |=> irq_o); // R7

    AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(status & ien)) |=> !irq_o); // R7

    AST_WAKE_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status & wake)) |=> wake_o); // R8

    AST_WAKE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(status & wake)) |=> !wake_o); // R8

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|edge_hit) |=> (status & $past(edge_hit)) == $past(edge_hit)); // R9

endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(.NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .status    (status_q),
    .ien       (ien_q),
    .wake      (wake_q),
    .edge_hit  (edge_hit),
    .irq_o     (irq_o),
    .wake_o    (wake_o)
);

// File: tb/gpio_edge_bank_test.sv
// Bench: scoreboard style. Driver tasks push expected items into a queue
// at a quiet point of the cycle; a monitor process pops each one and
// compares it with the design's outputs.
module gpio_edge_bank_test;

    localparam int CLK_PERIOD = 10;
    localparam int NPINS      = 36;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [5:0]       reg_addr;
    logic [31:0]      reg_wdata;
    logic             reg_we;
    logic [31:0]      reg_rdata;
    logic [NPINS-1:0] pin_in;
    logic [NPINS-1:0] pin_out;
    logic [NPINS-1:0] pin_oe;
    logic             irq_o;
    logic             wake_o;

    gpio_edge_bank #(.NPINS(NPINS)) uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_o(irq_o), .wake_o(wake_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Kinds of observation: 0 read data, 1 irq_o, 2 wake_o, 3 pin_out low, 4 pin_oe low
    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    event     push_ev;
    int       checks = 0;
    int       errors = 0;
    bit       done   = 1'b0;

    // Monitor: pop expected items and compare with the outputs.
    initial begin
        forever begin
            @(push_ev);
            while (sb_q.size() != 0) begin
                sb_item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    0:       act = reg_rdata;
                    1:       act = {31'd0, irq_o};
                    2:       act = {31'd0, wake_o};
                    3:       act = pin_out[31:0];
                    default: act = pin_oe[31:0];
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic push(input int kind, input logic [31:0] exp, input string tag);
        sb_item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        -> push_ev;
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic chk_rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a; reg_we = 1'b0;
        #(CLK_PERIOD/4);
        push(0, exp, tag);
    endtask

    task automatic chk_sig(input int kind, input logic [31:0] exp, input string tag);
        @(negedge clk);
        #(CLK_PERIOD/4);
        push(kind, exp, tag);
    endtask

    task automatic set_pins(input logic [NPINS-1:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    // Watchdog.
    initial begin
        #(CLK_PERIOD*200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; reg_addr = '0; reg_wdata = '0; reg_we = 1'b0; pin_in = '0;
        idle(4);
        rst_n = 1'b1;

        // R1: reset state
        chk_rd(6'h00, 32'h0, "R1 oe");
        chk_rd(6'h30, 32'h0, "R1 status");
        chk_rd(6'h28, 32'h0, "R1 pol");
        chk_sig(1, 32'h0, "R1 irq_o");
        chk_sig(2, 32'h0, "R1 wake_o");
        chk_sig(4, 32'h0, "R1 pin_oe");

        // R2: direction and output value
        wr(6'h00, 32'h0000_00FF);
        wr(6'h18, 32'h0000_0F0F);
        chk_sig(3, 32'h0000_000F, "R2 pin_out gated");
        chk_sig(4, 32'h0000_00FF, "R2 pin_oe");
        chk_rd(6'h18, 32'h0000_0F0F, "R2 out readback");

        // R3 / R4 / R7: inputs rise on bits 0,2,5,7 and 33,35 with enables off
        set_pins(36'hA_0000_00A5);
        idle(4);
        chk_rd(6'h10, 32'h0000_00A5, "R3 input low");
        chk_rd(6'h14, 32'h0000_000A, "R10 input high");
        wr(6'h10, 32'hFFFF_FFFF);
        chk_rd(6'h10, 32'h0000_00A5, "R3 input write ignored");
        chk_rd(6'h30, 32'h0000_00A5, "R4 rising sets status");
        chk_rd(6'h34, 32'h0000_000A, "R10 high status");
        chk_sig(1, 32'h0, "R7 latch without enable, irq low");

        // R6: write-one-to-clear
        wr(6'h30, 32'h0000_0005);
        chk_rd(6'h30, 32'h0000_00A0, "R6 partial clear");
        wr(6'h30, 32'h0000_0000);
        chk_rd(6'h30, 32'h0000_00A0, "R6 zero write keeps");
        wr(6'h30, 32'h0000_00A0);
        wr(6'h34, 32'h0000_0002);
        chk_rd(6'h34, 32'h0000_0008, "R10 high partial clear");
        wr(6'h34, 32'h0000_0008);
        chk_rd(6'h30, 32'h0, "R6 fully cleared");

        // R4: falling edge ignored at polarity 0
        set_pins(36'hA_0000_0000);
        idle(4);
        chk_rd(6'h30, 32'h0, "R4 falling ignored");

        // R5: polarity 1 on bits 0..3
        wr(6'h28, 32'h0000_000F);
        set_pins(36'hA_0000_000F);
        idle(4);
        chk_rd(6'h30, 32'h0, "R5 rising ignored");
        set_pins(36'hA_0000_0000);
        idle(4);
        chk_rd(6'h30, 32'h0000_000F, "R5 falling sets");
        wr(6'h30, 32'h0000_000F);

        // R7: interrupt output on enabled bit 0 (falling polarity)
        wr(6'h20, 32'h0000_0001);
        set_pins(36'hA_0000_0001);
        idle(4);
        chk_sig(1, 32'h0, "R7 no irq on rise");
        set_pins(36'hA_0000_0000);
        idle(4);
        chk_rd(6'h30, 32'h0000_0001, "R7 status bit0");
        chk_sig(1, 32'h1, "R7 irq raised");
        wr(6'h30, 32'h0000_0001);
        chk_sig(1, 32'h0, "R7 irq dropped after clear");

        // R8: wake on bit 4 (rising)
        wr(6'h38, 32'h0000_0010);
        set_pins(36'hA_0000_0010);
        idle(4);
        chk_sig(2, 32'h1, "R8 wake raised");
        chk_sig(1, 32'h0, "R8 irq stays low");
        set_pins(36'hA_0000_0000);
        idle(4);

        // R9: new rising edge on bit 4 meets a clear of bit 4 in one cycle
        set_pins(36'hA_0000_0010);
        idle(1);
        wr(6'h30, 32'h0000_0010);
        chk_rd(6'h30, 32'h0000_0010, "R9 set wins");
        chk_sig(2, 32'h1, "R9 wake still high");
        wr(6'h30, 32'h0000_0010);
        chk_rd(6'h30, 32'h0, "R9 later clear");
        chk_sig(2, 32'h0, "R8 wake dropped");

        // R10: high word population, unmapped address, high-pin interrupt
        wr(6'h04, 32'hFFFF_FFFF);
        chk_rd(6'h04, 32'h0000_000F, "R10 oe high masked");
        wr(6'h08, 32'hFFFF_FFFF);
        chk_rd(6'h08, 32'h0, "R10 unmapped reads 0");
        wr(6'h24, 32'hFFFF_FFFF);
        chk_rd(6'h24, 32'h0000_000F, "R10 enable high masked");
        set_pins(36'hE_0000_0010);
        idle(4);
        chk_rd(6'h34, 32'h0000_0004, "R10 pin34 status");
        chk_sig(1, 32'h1, "R10 irq from high pin");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule